// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Masked Output Writes and Shared Interrupt

This block drives and samples sixteen general-purpose pins from a word-addressed register bus. Software chooses per-pin direction, sets output values through a write that carries its own per-bit update mask (so several agents can touch different pins without a read-modify-write), and reads back the pin levels after a two-flop synchronizer. The upper eight pins feed one shared, active-high interrupt request: each synchronized level is gated by its own enable bit and the gated results are ORed together.

A two-bit control register holds the block's mode. It is a small state machine: writes to it may change the mode in any mode, and it resets to the parked state. The four states are MODE_IDLE (code 0: clock off, not in reset; the registers keep their contents and ignore writes), MODE_RUN (code 1: clock on; normal operation), MODE_PARK (code 2: in reset with the clock off; this is the low-power state) and MODE_RESET (code 3: in reset with the clock on). Each transition is named by its target: a control write of value v moves the machine from any state to the state with code v[1:0]. The usual bring-up is a write of 3 followed by a write of 1; a write of 2 shuts the block down.

Top module: `pinbank_ctrl`

## Requirements
- R1: After the asynchronous reset the control register reads 2, the direction, output and interrupt-enable registers read 0, pin_oe and pin_out are 0 and irq_req is low.
- R2: A write to offset 0x00 in MODE_RUN stores bits 15:0 as the direction; bit n set drives pin_oe[n] high. A read returns the stored value with bits 31:16 at zero.
- R3: A write to offset 0x08 in MODE_RUN updates output bit n to wdata[n] only when wdata[n+16] is 1; bits whose mask is 0 keep their value. A read returns the 16 output values in bits 15:0 with bits 31:16 at zero, and pin_out shows the same values.
- R4: A read of offset 0x0C returns pin_in in bits 15:0 exactly two clock edges after it was applied, with bits 31:16 at zero.
- R5: irq_req is high exactly when some pin n in 8..15 has a synchronized level of 1 and its enable bit set; levels on pins 0..7 never raise it.
- R6: With the default placement (IEN_LOW = 0) the interrupt-enable register at offset 0x10 holds the enable of pin n at bit n for n = 8..15; bits 7:0 and 31:16 read as zero and writes to them have no effect. With IEN_LOW = 1 the same enables sit at bits 7:0.
- R7: A write to offset 0x14 loads wdata[1:0] into the mode in every state; bit 0 is the clock enable and bit 1 the reset hold. A read returns the mode in bits 1:0 and zero above.
- R8: While bit 1 of the mode is set, the direction, output and interrupt-enable registers are cleared on the next edge and stay zero; writes to them have no effect and irq_req is low.
- R9: In MODE_IDLE writes to the direction, output and interrupt-enable registers are ignored and their contents are kept.
- R10: Reads of offsets not listed above return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output values |
| pin_oe | output | 16 | Per-pin output enable |
| irq_req | output | 1 | Shared active-high interrupt request |

## Verification
The shared request can see a synchronized pin rising in the very cycle that a bus write clears that pin's enable bit. The bench provokes this by changing pin 9 one edge before the enable write, so the second synchronizer stage and the new enable value land on the same edge. It judges the outcome by requiring irq_req to stay low after that edge while the level read at offset 0x0C already shows the pin high, and then by re-enabling the pin and seeing the request rise.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_DIR = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_OUT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_LVL = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_IEN = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CTL = 8'h14;

    // bit 0: clock enable, bit 1: reset hold
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_RUN   = 2'b01,
        MODE_PARK  = 2'b10,
        MODE_RESET = 2'b11
    } mode_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq #(
    parameter int COUNT = 8
) (
    input  logic [COUNT-1:0] lvl,
    input  logic [COUNT-1:0] ien,
    output logic             irq
);
    logic [COUNT-1:0] hit;

    for (genvar g = 0; g < COUNT; g++) begin : g_gate
        assign hit[g] = lvl[g] & ien[g];
    end

    assign irq = |hit;
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int NPINS     = 16,
    parameter int IRQ_FIRST = 8,
    parameter int IRQ_COUNT = 8,
    parameter bit IEN_LOW   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NPINS-1:0]  pin_lvl,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  out_q,
    output logic [IRQ_COUNT-1:0] ien_q,
    output mode_e             mode_q
);
    localparam int IEN_POS  = IEN_LOW ? 0 : IRQ_FIRST;
    localparam int MASK_POS = DATA_W / 2;

    mode_e mode_d;
    logic  clk_on;
    logic  hold;
    logic  wr_dir, wr_out, wr_ien;
    logic [NPINS-1:0] wmask;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_PARK;
        else        mode_q <= mode_d;
    end

    // transitions: any control write moves to the written state
    always_comb begin
        mode_d = mode_q;
        if (bus_wr && bus_addr == OFS_CTL)
            mode_d = mode_e'(bus_wdata[1:0]);
    end

    // state outputs
    always_comb begin
        unique case (mode_q)
            MODE_IDLE:  begin clk_on = 1'b0; hold = 1'b0; end
            MODE_RUN:   begin clk_on = 1'b1; hold = 1'b0; end
            MODE_PARK:  begin clk_on = 1'b0; hold = 1'b1; end
            MODE_RESET: begin clk_on = 1'b1; hold = 1'b1; end
            default:    begin clk_on = 1'b0; hold = 1'b1; end
        endcase
    end

    assign wr_dir = bus_wr && clk_on && bus_addr == OFS_DIR;
    assign wr_out = bus_wr && clk_on && bus_addr == OFS_OUT;
    assign wr_ien = bus_wr && clk_on && bus_addr == OFS_IEN;
    assign wmask  = bus_wdata[MASK_POS +: NPINS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
            ien_q <= '0;
        end else if (hold) begin
            dir_q <= '0;
            out_q <= '0;
            ien_q <= '0;
        end else begin
            if (wr_dir) dir_q <= bus_wdata[NPINS-1:0];
            if (wr_out) out_q <= (out_q & ~wmask) | (bus_wdata[NPINS-1:0] & wmask);
            if (wr_ien) ien_q <= bus_wdata[IEN_POS +: IRQ_COUNT];
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_DIR: bus_rdata = DATA_W'(dir_q);
            OFS_OUT: bus_rdata = DATA_W'(out_q);
            OFS_LVL: bus_rdata = DATA_W'(pin_lvl);
            OFS_IEN: bus_rdata = DATA_W'(ien_q) << IEN_POS;
            OFS_CTL: bus_rdata = DATA_W'(mode_q);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NPINS     = 16,
    parameter int IRQ_FIRST = 8,
    parameter int IRQ_COUNT = 8,
    parameter bit IEN_LOW   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_req
);
    logic [NPINS-1:0]     pin_lvl;
    logic [IRQ_COUNT-1:0] ien_q;
    mode_e                mode_q;

    pinbank_sync #(.WIDTH(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_lvl)
    );

    pinbank_regs #(
        .NPINS     (NPINS),
        .IRQ_FIRST (IRQ_FIRST),
        .IRQ_COUNT (IRQ_COUNT),
        .IEN_LOW   (IEN_LOW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_lvl   (pin_lvl),
        .bus_rdata (bus_rdata),
        .dir_q     (pin_oe),
        .out_q     (pin_out),
        .ien_q     (ien_q),
        .mode_q    (mode_q)
    );

    pinbank_irq #(.COUNT(IRQ_COUNT)) u_irq (
        .lvl (pin_lvl[IRQ_FIRST +: IRQ_COUNT]),
        .ien (ien_q),
        .irq (irq_req)
    );
endmodule

// File: rtl/pinbank_checker.sv
module pinbank_checker
    import pinbank_pkg::*;
#(
    parameter int NPINS     = 16,
    parameter int IRQ_FIRST = 8,
    parameter int IRQ_COUNT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq_req,
    input logic [1:0]        mode_q
);
    localparam int MASK_POS = DATA_W / 2;

    p_mask_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_OUT && mode_q == 2'b01)
        |=> (((pin_out ^ $past(pin_out)) & ~$past(bus_wdata[MASK_POS +: NPINS])) == '0));

    p_irq_needs_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ($past(pin_in[IRQ_FIRST +: IRQ_COUNT], 2) != '0));

    p_ctrl_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTL) |=> (mode_q == $past(bus_wdata[1:0])));

    p_hold_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[1] |=> (pin_oe == '0 && pin_out == '0 && !irq_req));

    p_idle_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b00) |=> ($stable(pin_oe) && $stable(pin_out)));
endmodule

bind pinbank_ctrl pinbank_checker #(
    .NPINS     (NPINS),
    .IRQ_FIRST (IRQ_FIRST),
    .IRQ_COUNT (IRQ_COUNT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_req   (irq_req),
    .mode_q    (mode_q)
);

// File: tb/tb_pinbank_ctrl.sv
module tb_pinbank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic        irq_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    pinbank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_req(irq_req)
    );

    // {addr, write data, expected read-back at the same address}
    localparam logic [71:0] VEC [8] = '{
        {8'h00, 32'h0000_A5F0, 32'h0000_A5F0},  // R2 direction
        {8'h08, 32'hFFFF_1234, 32'h0000_1234},  // R3 full mask
        {8'h08, 32'h00FF_00FF, 32'h0000_12FF},  // R3 low byte only
        {8'h08, 32'hF000_0000, 32'h0000_02FF},  // R3 clear top nibble
        {8'h08, 32'h0000_FFFF, 32'h0000_02FF},  // R3 empty mask
        {8'h10, 32'hFFFF_FFFF, 32'h0000_FF00},  // R6 only bits 15:8 kept
        {8'h10, 32'h0000_0F00, 32'h0000_0F00},  // R6 pins 8..11
        {8'h04, 32'hFFFF_FFFF, 32'h0000_0000}   // R10 unmapped
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    initial begin
        logic [31:0] d;
        edges(3);
        @(negedge clk) rst_n = 1'b1;

        rd(8'h14, d); chk("R1 ctrl after reset", d, 32'h2);
        rd(8'h00, d); chk("R1 direction after reset", d, 32'h0);
        rd(8'h08, d); chk("R1 output after reset", d, 32'h0);
        rd(8'h10, d); chk("R1 enable after reset", d, 32'h0);
        chk("R1 pins and irq after reset", {15'd0, irq_req, pin_oe}, 32'h0);

        wr(8'h14, 32'h3);
        wr(8'h14, 32'h1);
        rd(8'h14, d); chk("R7 ctrl run", d, 32'h1);

        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], d);
            chk("R2 R3 R6 R10 table", d, VEC[i][31:0]);
        end
        chk("R2 pin_oe", {16'd0, pin_oe}, 32'h0000_A5F0);
        chk("R3 pin_out", {16'd0, pin_out}, 32'h0000_02FF);

        // R4 two-edge latency
        @(negedge clk) pin_in = 16'h5A3C;
        rd(8'h0C, d); chk("R4 level after one edge", d, 32'h0);
        rd(8'h0C, d); chk("R4 level after two edges", d, 32'h0000_5A3C);

        // R5 shared request, enables = pins 8..11
        @(negedge clk) pin_in = 16'h00FF;
        edges(3); chk("R5 low pins ignored", {31'd0, irq_req}, 32'h0);
        @(negedge clk) pin_in = 16'h0100;
        edges(3); chk("R5 pin 8 enabled", {31'd0, irq_req}, 32'h1);
        @(negedge clk) pin_in = 16'h1000;
        edges(3); chk("R5 pin 12 not enabled", {31'd0, irq_req}, 32'h0);

        // R5 same edge: level of pin 9 arrives as its enable is cleared
        @(negedge clk) pin_in = 16'h0200;
        wr(8'h10, 32'h0);
        chk("R5 enable cleared on arrival edge", {31'd0, irq_req}, 32'h0);
        rd(8'h0C, d); chk("R4 level pin 9", d, 32'h0000_0200);
        wr(8'h10, 32'h0000_0200);
        chk("R5 pin 9 re-enabled", {31'd0, irq_req}, 32'h1);
        wr(8'h10, 32'h0000_00FF);
        rd(8'h10, d); chk("R6 low bits not stored", d, 32'h0);
        chk("R6 irq off after low-bit write", {31'd0, irq_req}, 32'h0);

        wr(8'h14, 32'hFFFF_FFFD);
        rd(8'h14, d); chk("R7 upper control bits dropped", d, 32'h1);

        // R9 idle mode
        wr(8'h14, 32'h0);
        rd(8'h14, d); chk("R7 ctrl idle", d, 32'h0);
        wr(8'h00, 32'h0000_FFFF);
        rd(8'h00, d); chk("R9 direction kept", d, 32'h0000_A5F0);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, d); chk("R9 output kept", d, 32'h0000_02FF);
        chk("R9 pin_out kept", {16'd0, pin_out}, 32'h0000_02FF);

        // R8 reset hold
        wr(8'h14, 32'h3);
        edges(1);
        rd(8'h00, d); chk("R8 direction cleared", d, 32'h0);
        rd(8'h08, d); chk("R8 output cleared", d, 32'h0);
        wr(8'h00, 32'h0000_FFFF);
        rd(8'h00, d); chk("R8 write blocked", d, 32'h0);
        chk("R8 pin_oe low", {16'd0, pin_oe}, 32'h0);
        wr(8'h14, 32'h1);
        wr(8'h00, 32'h0000_0003);
        rd(8'h00, d); chk("R2 direction after release", d, 32'h3);
        wr(8'h10, 32'h0000_0200);
        chk("R5 request before park", {31'd0, irq_req}, 32'h1);
        wr(8'h14, 32'h2);
        edges(1);
        chk("R8 parked irq and pins", {15'd0, irq_req, pin_oe}, 32'h0);
        rd(8'h10, d); chk("R8 enable cleared", d, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule